// File: doc/BRIEF.md
# H-Bridge PWM Output Steering Unit

This block sits between per-channel PWM generators and the pad ring of a motor-driver output stage. For each motor channel it takes one PWM waveform and places it on one of two pins, a plus pin and a minus pin. Each pin has its own output-enable, so the pin can be released. A 2-bit mode field sets what the channel does. A sign bit picks which pin carries the waveform. A recirculation bit sets the static level of the other pin and the polarity of the waveform. Channels come in pairs (2n, 2n+1). A pair can be joined into a dual full-bridge, in which both channels take new settings together.

Mode, sign and recirculation go into a shadow register for each channel. The shadow register loads only when the channel's period-start strobe is high. Between period starts the pins therefore keep their behaviour, whatever the setting inputs do. After reset every channel is disabled and all pins are released.

Top module: `hbridge_steer`

## Requirements
- R1: While reset is asserted, and after it until the first load, every pin has its output-enable low and a drive value of 0.
- R2: An active mode of 00 (disabled) releases both pins of the channel: output-enables 0 and drive values 0.
- R3: In active mode 10 (full bridge) with sign 0, the plus pin drives PWM XOR recirc and the minus pin drives recirc. Both output-enables are 1.
- R4: In full-bridge operation with sign 1, the minus pin drives PWM XOR recirc and the plus pin drives recirc. Both output-enables are 1.
- R5: In active mode 01 (half bridge), the plus pin drives the PWM unchanged with its output-enable at 1. The minus pin is released (enable 0, value 0). Sign and recirculation have no effect.
- R6: A channel's mode, sign and recirculation settings are taken in at the clock edge where its load strobe is high. They govern the pins from the next cycle on. Setting changes with no strobe do not alter the pins.
- R7: When both channels of a pair present mode 11 at their inputs, both channels load on the even channel's period-start strobe and the odd channel's strobe is ignored. With both channels active in mode 11, each channel drives its pins as in R3/R4 using its own sign and recirculation bits.
- R8: A channel whose active mode is 11 while its partner's active mode is not 11 releases both of its pins.
- R9: When the pending settings are not both mode 11, each channel of a pair loads only on its own period-start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_start | input | 2*NPAIR | Period-start strobe for each channel |
| pwm_in | input | 2*NPAIR | PWM waveform for each channel |
| mode_in | input | 4*NPAIR | Pending 2-bit mode for each channel (channel c at bits 2c+1:2c) |
| sign_in | input | 2*NPAIR | Pending sign bit for each channel |
| recirc_in | input | 2*NPAIR | Pending recirculation bit for each channel |
| pin_p | output | 2*NPAIR | Plus-pin drive value |
| pin_m | output | 2*NPAIR | Minus-pin drive value |
| oe_p | output | 2*NPAIR | Plus-pin output-enable |
| oe_m | output | 2*NPAIR | Minus-pin output-enable |

## Verification
Every combination of mode, sign and recirculation is applied with the PWM both low and high. This separates steering (which pin moves with the PWM) from polarity (whether the PWM is inverted) and from the static level of the idle pin. Setting changes applied without a strobe, and strobes on only one channel, show whether loading is gated per channel. They also show whether a pair in mode 11 loads as one unit on the even strobe and ignores the odd one. A mode-11 channel paired with a full-bridge partner separates a joined pair from one that is not.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        HB_OFF  = 2'b00,
        HB_HALF = 2'b01,
        HB_FULL = 2'b10,
        HB_DUAL = 2'b11
    } hb_mode_e;

    typedef struct packed {
        hb_mode_e mode;
        logic     sign;
        logic     recirc;
    } hb_cfg_t;

    localparam hb_cfg_t HB_CFG_RST = '{mode: HB_OFF, sign: 1'b0, recirc: 1'b0};

endpackage

// File: rtl/hb_shadow.sv
module hb_shadow
    import hb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  hb_cfg_t cfg_i,
    output hb_cfg_t cfg_o
);

    hb_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d = cfg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= HB_CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/hb_pin_mux.sv
module hb_pin_mux
    import hb_pkg::*;
(
    input  hb_cfg_t  cfg,
    input  hb_mode_e partner_mode,
    input  logic     pwm,
    output logic     pin_p,
    output logic     pin_m,
    output logic     oe_p,
    output logic     oe_m
);

    logic bridge_on;
    logic wave;

    always_comb begin
        bridge_on = (cfg.mode == HB_FULL) ||
                    ((cfg.mode == HB_DUAL) && (partner_mode == HB_DUAL));
        wave  = pwm ^ cfg.recirc;
        pin_p = 1'b0;
        pin_m = 1'b0;
        oe_p  = 1'b0;
        oe_m  = 1'b0;
        if (cfg.mode == HB_HALF) begin
            pin_p = pwm;
            oe_p  = 1'b1;
        end else if (bridge_on) begin
            oe_p  = 1'b1;
            oe_m  = 1'b1;
            if (cfg.sign) begin
                pin_p = cfg.recirc;
                pin_m = wave;
            end else begin
                pin_p = wave;
                pin_m = cfg.recirc;
            end
        end
    end

endmodule

// File: rtl/hbridge_steer.sv
module hbridge_steer
    import hb_pkg::*;
#(
    parameter int NPAIR = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*NPAIR-1:0]   period_start,
    input  logic [2*NPAIR-1:0]   pwm_in,
    input  logic [4*NPAIR-1:0]   mode_in,
    input  logic [2*NPAIR-1:0]   sign_in,
    input  logic [2*NPAIR-1:0]   recirc_in,
    output logic [2*NPAIR-1:0]   pin_p,
    output logic [2*NPAIR-1:0]   pin_m,
    output logic [2*NPAIR-1:0]   oe_p,
    output logic [2*NPAIR-1:0]   oe_m
);

    localparam int NCH = 2 * NPAIR;

    hb_cfg_t          act_cfg [NCH];
    logic [2*NCH-1:0] act_mode;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int EV = (c / 2) * 2;
        localparam int OD = EV + 1;
        localparam int PT = (c == EV) ? OD : EV;

        logic    pend_dual;
        logic    load;
        hb_cfg_t pend_cfg;

        // Joined pair: both channels take settings on the even strobe.
        assign pend_dual = (mode_in[2*EV +: 2] == 2'b11) && (mode_in[2*OD +: 2] == 2'b11);
        assign load      = (c == EV) ? period_start[EV]
                                     : (pend_dual ? period_start[EV] : period_start[c]);
        assign pend_cfg  = '{mode:   hb_mode_e'(mode_in[2*c +: 2]),
                             sign:   sign_in[c],
                             recirc: recirc_in[c]};

        hb_shadow u_shadow (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .cfg_i (pend_cfg),
            .cfg_o (act_cfg[c])
        );

        hb_pin_mux u_mux (
            .cfg          (act_cfg[c]),
            .partner_mode (act_cfg[PT].mode),
            .pwm          (pwm_in[c]),
            .pin_p        (pin_p[c]),
            .pin_m        (pin_m[c]),
            .oe_p         (oe_p[c]),
            .oe_m         (oe_m[c])
        );

        assign act_mode[2*c +: 2] = act_cfg[c].mode;
    end

endmodule

// File: rtl/hb_steer_chk.sv
module hb_steer_chk #(
    parameter int NPAIR = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*NPAIR-1:0]   period_start,
    input logic [2*NPAIR-1:0]   pwm_in,
    input logic [4*NPAIR-1:0]   act_mode,
    input logic [2*NPAIR-1:0]   pin_p,
    input logic [2*NPAIR-1:0]   pin_m,
    input logic [2*NPAIR-1:0]   oe_p,
    input logic [2*NPAIR-1:0]   oe_m
);

    localparam int NCH = 2 * NPAIR;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        localparam int EV = (c / 2) * 2;
        localparam int OD = EV + 1;
        localparam int PT = (c == EV) ? OD : EV;

        a_r1_reset_released: assert property (@(posedge clk)
            !rst_n |-> (!oe_p[c] && !oe_m[c]));

        a_r2_off_released: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mode[2*c +: 2] == 2'b00) |-> (!oe_p[c] && !oe_m[c]));

        a_r3_full_both_driven: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mode[2*c +: 2] == 2'b10) |-> (oe_p[c] && oe_m[c] && (pin_p[c] != pin_m[c] || !pwm_in[c] || pwm_in[c])));

        a_r5_half_minus_released: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mode[2*c +: 2] == 2'b01) |-> (oe_p[c] && !oe_m[c] && (pin_p[c] == pwm_in[c])));

        a_r8_unpaired_released: assert property (@(posedge clk) disable iff (!rst_n)
            ((act_mode[2*c +: 2] == 2'b11) && (act_mode[2*PT +: 2] != 2'b11))
            |-> (!oe_p[c] && !oe_m[c]));

        a_r6_hold_between_starts: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(period_start[EV] || period_start[OD]) && $stable(pwm_in[c]))
            |-> $stable({pin_p[c], pin_m[c], oe_p[c], oe_m[c]}));
    end

endmodule

bind hbridge_steer hb_steer_chk #(.NPAIR(NPAIR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .pwm_in       (pwm_in),
    .act_mode     (act_mode),
    .pin_p        (pin_p),
    .pin_m        (pin_m),
    .oe_p         (oe_p),
    .oe_m         (oe_m)
);

// File: tb/test_hbridge_steer.sv
`timescale 1ns/1ps
module test_hbridge_steer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] period_start = '0;
    logic [1:0] pwm_in = '0;
    logic [3:0] mode_in = '0;
    logic [1:0] sign_in = '0;
    logic [1:0] recirc_in = '0;
    logic [1:0] pin_p, pin_m, oe_p, oe_m;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hbridge_steer #(.NPAIR(1)) i_hbridge_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .pwm_in       (pwm_in),
        .mode_in      (mode_in),
        .sign_in      (sign_in),
        .recirc_in    (recirc_in),
        .pin_p        (pin_p),
        .pin_m        (pin_m),
        .oe_p         (oe_p),
        .oe_m         (oe_m)
    );

    // Expected {pin_p, pin_m, oe_p, oe_m} from the requirements.
    function automatic logic [3:0] model(logic [1:0] md, logic [1:0] pm,
                                         logic sg, logic rc, logic pw);
        logic w;
        w = pw ^ rc;
        if (md == 2'b01) return {pw, 1'b0, 1'b1, 1'b0};
        if (md == 2'b10 || (md == 2'b11 && pm == 2'b11))
            return sg ? {rc, w, 2'b11} : {w, rc, 2'b11};
        return 4'b0000;
    endfunction

    task automatic chk(int c, logic [3:0] exp, string rq);
        logic [3:0] got;
        got = {pin_p[c], pin_m[c], oe_p[c], oe_m[c]};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d got %b expected %b", rq, c, got, exp);
        end
    endtask

    task automatic chk_both(int c, logic [1:0] md, logic [1:0] pm,
                            logic sg, logic rc, string rq);
        for (int pw = 0; pw < 2; pw++) begin
            @(negedge clk);
            pwm_in[c] = pw[0];
            #1;
            chk(c, model(md, pm, sg, rc, pw[0]), rq);
        end
    endtask

    task automatic set_cfg(int c, logic [1:0] md, logic sg, logic rc);
        mode_in[2*c +: 2] = md;
        sign_in[c]        = sg;
        recirc_in[c]      = rc;
    endtask

    task automatic pulse(logic [1:0] mask);
        @(negedge clk);
        period_start = mask;
        @(negedge clk);
        period_start = '0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(0, 4'b0000, "R1");
        chk(1, 4'b0000, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(0, 4'b0000, "R1");
        chk(1, 4'b0000, "R1");
    endtask

    task automatic t_off;
        set_cfg(0, 2'b00, 1'b1, 1'b1);
        set_cfg(1, 2'b00, 1'b0, 1'b1);
        pulse(2'b11);
        chk_both(0, 2'b00, 2'b00, 1'b1, 1'b1, "R2");
        chk_both(1, 2'b00, 2'b00, 1'b0, 1'b1, "R2");
    endtask

    task automatic t_full;
        for (int k = 0; k < 4; k++) begin
            set_cfg(0, 2'b10, k[0], k[1]);
            set_cfg(1, 2'b10, ~k[0], k[1]);
            pulse(2'b11);
            chk_both(0, 2'b10, 2'b10, k[0], k[1], k[0] ? "R4" : "R3");
            chk_both(1, 2'b10, 2'b10, ~k[0], k[1], k[0] ? "R3" : "R4");
        end
    endtask

    task automatic t_half;
        for (int k = 0; k < 4; k++) begin
            set_cfg(0, 2'b01, k[0], k[1]);
            set_cfg(1, 2'b01, k[1], k[0]);
            pulse(2'b11);
            chk_both(0, 2'b01, 2'b01, k[0], k[1], "R5");
            chk_both(1, 2'b01, 2'b01, k[1], k[0], "R5");
        end
    endtask

    task automatic t_hold;
        set_cfg(0, 2'b10, 1'b0, 1'b0);
        set_cfg(1, 2'b00, 1'b0, 1'b0);
        pulse(2'b11);
        set_cfg(0, 2'b01, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk_both(0, 2'b10, 2'b00, 1'b0, 1'b0, "R6 hold");
        pulse(2'b01);
        chk_both(0, 2'b01, 2'b00, 1'b1, 1'b1, "R6 load");
    endtask

    task automatic t_dual;
        set_cfg(0, 2'b11, 1'b0, 1'b1);
        set_cfg(1, 2'b11, 1'b1, 1'b0);
        pulse(2'b01);
        chk_both(0, 2'b11, 2'b11, 1'b0, 1'b1, "R7 even strobe");
        chk_both(1, 2'b11, 2'b11, 1'b1, 1'b0, "R7 even strobe");
        set_cfg(1, 2'b11, 1'b0, 1'b1);
        pulse(2'b10);
        chk_both(1, 2'b11, 2'b11, 1'b1, 1'b0, "R7 odd ignored");
        pulse(2'b01);
        chk_both(1, 2'b11, 2'b11, 1'b0, 1'b1, "R7 reload");
    endtask

    task automatic t_unpaired;
        set_cfg(0, 2'b11, 1'b0, 1'b0);
        set_cfg(1, 2'b10, 1'b1, 1'b1);
        pulse(2'b11);
        chk_both(0, 2'b11, 2'b10, 1'b0, 1'b0, "R8");
        chk_both(1, 2'b10, 2'b11, 1'b1, 1'b1, "R8 partner");
    endtask

    task automatic t_indep;
        set_cfg(0, 2'b10, 1'b0, 1'b0);
        set_cfg(1, 2'b10, 1'b0, 1'b0);
        pulse(2'b11);
        set_cfg(0, 2'b10, 1'b1, 1'b1);
        set_cfg(1, 2'b10, 1'b1, 1'b1);
        pulse(2'b10);
        chk_both(1, 2'b10, 2'b10, 1'b1, 1'b1, "R9 own strobe");
        chk_both(0, 2'b10, 2'b10, 1'b0, 1'b0, "R9 other kept");
        pulse(2'b01);
        chk_both(0, 2'b10, 2'b10, 1'b1, 1'b1, "R9 own strobe");
    endtask

    initial begin
        t_reset();
        t_off();
        t_full();
        t_half();
        t_hold();
        t_dual();
        t_unpaired();
        t_indep();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule